// File: doc/BRIEF.md
# Video Memory Read Prefetch Unit

This block serves host reads from the data port of a video controller. Once a read command is in place, it uses the free memory-access slots the controller grants to fetch the next word ahead of time. It can fetch from byte-wide video RAM, from colour RAM or from vertical-scroll RAM. When a fetch completes, the block holds a 16-bit prefetch word, raises a ready flag and advances its address by the increment amount. A 16-bit host read waits until the ready flag is set and then takes the word. A legacy 8-bit host read takes whatever the prefetch register holds and switches the unit to byte-wide video RAM reads.

The colour and scroll memories are narrower than 16 bits. The bits they do not implement are filled from the write-FIFO entry at the current write pointer, which the controller presents on an input. A 16-bit video RAM word is built from two byte fetches on two separate slots. A flag records that the upper byte is already held.

Top module: `vram_prefetch_top`

## Requirements
- R1: A fetch happens only on a cycle with `slot_ok` high. The access code must have bit 0 clear, the ready flag must be low and no half-written command may be pending. While the ready flag is high, further slots leave the word and the address untouched.
- R2: Code 0x0 reads a 16-bit video RAM word over two slots. The first slot reads the byte at the address with bit 0 cleared into bits 15:8 and sets the read-pending flag. The second slot reads the byte at the address with bit 0 set into bits 7:0 and raises the ready flag.
- R3: The address advances by `incr`, modulo 2^16, each time a fetch completes, for every memory type. A host read does not change the address.
- R4: Code 0xC reads one byte from video RAM at the full address into bits 7:0. Bits 15:8 are copied from bits 15:8 of `fifo_val`. The ready flag rises after one slot.
- R5: Code 0x8 reads colour RAM at index (address/2) modulo its depth. Bits above its data width are copied from `fifo_val`.
- R6: Code 0x4 reads scroll RAM at index (address/2) AND 63. An index at or above the scroll RAM depth is replaced by 0. Bits above its data width are copied from `fifo_val`.
- R7: `rd16_ack` is high only while `rd16_req` is high and the ready flag is set. `rd_data` then carries the word, and the ready flag is low on the next cycle.
- R8: A cycle with `rd8_req` high presents the current prefetch word on `rd_data` and clears the ready flag and the command-pending flag. It sets the access code to 0xC (byte video RAM read). It does not change the address.
- R9: After reset the access code is 0x1, which does not fetch, and all flags are low. `cmd_hi` sets the command-pending flag. `cmd_load` loads the code and address and clears the ready, read-pending and command-pending flags. `cmd_load` takes priority over `rd8_req`, and `rd8_req` takes priority over a fetch.
- R10: Only the codes 0x0, 0x4, 0x8 and 0xC fetch. Any other code, even or odd, leaves the ready flag low however many slots arrive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_hi | input | 1 | First half of a command written; sets the pending flag |
| cmd_load | input | 1 | Command complete; loads code and address |
| cmd_code | input | 4 | Access code to load |
| cmd_addr | input | 16 | Address to load |
| incr | input | 8 | Address step applied per completed fetch |
| slot_ok | input | 1 | A free memory slot is available this cycle |
| vram_addr | output | 16 | Video RAM byte address |
| vram_re | output | 1 | Video RAM read this cycle |
| vram_rdata | input | 8 | Video RAM byte, same cycle |
| cram_idx | output | 6 | Colour RAM index |
| cram_re | output | 1 | Colour RAM read this cycle |
| cram_rdata | input | 9 | Colour RAM entry, same cycle |
| vsram_idx | output | 6 | Scroll RAM index |
| vsram_re | output | 1 | Scroll RAM read this cycle |
| vsram_rdata | input | 11 | Scroll RAM entry, same cycle |
| fifo_val | input | 16 | Value in the write-FIFO slot at the write pointer |
| rd16_req | input | 1 | 16-bit host read request, held until acknowledged |
| rd16_ack | output | 1 | 16-bit host read completes this cycle |
| rd8_req | input | 1 | Legacy 8-bit host read, one-cycle strobe |
| rd_data | output | 16 | Prefetch word returned to the host |
| pf_ready | output | 1 | Prefetch word is complete |

## Verification
The assertions assume the following about the inputs. The memories answer in the same cycle they are addressed. `rd16_req` stays high until `rd16_ack`. `cmd_load`, `rd8_req` and a pending 16-bit read never share a cycle. The scroll RAM depth is below the 64-entry index span. The stimulus drives every input on the falling edge, one strobe at a time, and answers memory reads from pure functions of the address. Stall cases overlap a waiting 16-bit read only with slot pulses.

// File: rtl/vram_prefetch_pkg.sv
package vram_prefetch_pkg;

    localparam int WORD_W = 16;

    localparam logic [3:0] CODE_VRAM16 = 4'h0;
    localparam logic [3:0] CODE_VSRAM  = 4'h4;
    localparam logic [3:0] CODE_CRAM   = 4'h8;
    localparam logic [3:0] CODE_VRAM8  = 4'hC;
    localparam logic [3:0] CODE_IDLE   = 4'h1;

    typedef enum logic [2:0] {
        SRC_NONE,
        SRC_VRAM_HI,
        SRC_VRAM_LO,
        SRC_VRAM8,
        SRC_CRAM,
        SRC_VSRAM
    } fetch_src_e;

    typedef struct packed {
        logic fetched;
        logic rd_pend;
        logic cmd_pend;
    } pf_flags_t;

    function automatic logic [WORD_W-1:0] fill_gaps(
        input logic [WORD_W-1:0] mem_bits,
        input logic [WORD_W-1:0] fifo,
        input logic [WORD_W-1:0] mask
    );
        return (mem_bits & mask) | (fifo & ~mask);
    endfunction

    function automatic fetch_src_e pick_src(input logic [3:0] code, input logic rd_pend);
        case (code)
            CODE_VRAM16: pick_src = rd_pend ? SRC_VRAM_LO : SRC_VRAM_HI;
            CODE_VRAM8:  pick_src = SRC_VRAM8;
            CODE_CRAM:   pick_src = SRC_CRAM;
            CODE_VSRAM:  pick_src = SRC_VSRAM;
            default:     pick_src = SRC_NONE;
        endcase
    endfunction

endpackage

// File: rtl/vram_prefetch_addr.sv
module vram_prefetch_addr
    import vram_prefetch_pkg::*;
#(
    parameter int ADDR_W   = 16,
    parameter int CRAM_AW  = 6,
    parameter int VS_AW    = 6,
    parameter int VS_DEPTH = 40
) (
    input  logic [ADDR_W-1:0]  addr,
    input  fetch_src_e         src,
    output logic [ADDR_W-1:0]  vram_addr,
    output logic               vram_re,
    output logic [CRAM_AW-1:0] cram_idx,
    output logic               cram_re,
    output logic [VS_AW-1:0]   vsram_idx,
    output logic               vsram_re
);
    localparam logic [VS_AW-1:0] VS_LIM = VS_AW'(VS_DEPTH);

    logic [VS_AW-1:0] vs_raw;

    always_comb begin
        case (src)
            SRC_VRAM_HI: vram_addr = {addr[ADDR_W-1:1], 1'b0};
            SRC_VRAM_LO: vram_addr = {addr[ADDR_W-1:1], 1'b1};
            default:     vram_addr = addr;
        endcase
        vram_re = (src == SRC_VRAM_HI) || (src == SRC_VRAM_LO) || (src == SRC_VRAM8);
    end

    // colour index: half the byte address, wrapped by the power-of-two depth
    assign cram_idx = addr[CRAM_AW:1];
    assign cram_re  = (src == SRC_CRAM);

    // scroll index: half the address within the index span, out-of-range forced to 0
    assign vs_raw    = addr[VS_AW:1];
    assign vsram_idx = (vs_raw >= VS_LIM) ? '0 : vs_raw;
    assign vsram_re  = (src == SRC_VSRAM);

endmodule

// File: rtl/vram_prefetch_merge.sv
module vram_prefetch_merge
    import vram_prefetch_pkg::*;
#(
    parameter int CRAM_W = 9,
    parameter int VS_W   = 11
) (
    input  fetch_src_e         src,
    input  logic [WORD_W-1:0]  prefetch,
    input  logic [7:0]         vram_rdata,
    input  logic [CRAM_W-1:0]  cram_rdata,
    input  logic [VS_W-1:0]    vsram_rdata,
    input  logic [WORD_W-1:0]  fifo_val,
    output logic [WORD_W-1:0]  pf_next
);
    localparam logic [WORD_W-1:0] CRAM_MASK = WORD_W'((1 << CRAM_W) - 1);
    localparam logic [WORD_W-1:0] VS_MASK   = WORD_W'((1 << VS_W) - 1);

    logic [WORD_W-1:0] cram_ext;
    logic [WORD_W-1:0] vs_ext;

    assign cram_ext = {{(WORD_W-CRAM_W){1'b0}}, cram_rdata};
    assign vs_ext   = {{(WORD_W-VS_W){1'b0}}, vsram_rdata};

    always_comb begin
        case (src)
            SRC_VRAM_HI: pf_next = {vram_rdata, 8'h00};
            SRC_VRAM_LO: pf_next = prefetch | {8'h00, vram_rdata};
            SRC_VRAM8:   pf_next = {fifo_val[15:8], vram_rdata};
            SRC_CRAM:    pf_next = fill_gaps(cram_ext, fifo_val, CRAM_MASK);
            SRC_VSRAM:   pf_next = fill_gaps(vs_ext, fifo_val, VS_MASK);
            default:     pf_next = prefetch;
        endcase
    end

endmodule

// File: rtl/vram_prefetch_ctrl.sv
module vram_prefetch_ctrl
    import vram_prefetch_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int INCR_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_hi,
    input  logic               cmd_load,
    input  logic [3:0]         cmd_code,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [INCR_W-1:0]  incr,
    input  logic               slot_ok,
    input  logic               rd16_req,
    input  logic               rd8_req,
    input  logic [WORD_W-1:0]  pf_next,
    output fetch_src_e         src,
    output logic [3:0]         code,
    output logic [ADDR_W-1:0]  addr,
    output pf_flags_t          flags,
    output logic [WORD_W-1:0]  prefetch,
    output logic               rd16_ack
);
    logic              can_fetch;
    logic              completes;
    logic [ADDR_W-1:0] incr_ext;

    assign incr_ext  = {{(ADDR_W-INCR_W){1'b0}}, incr};
    assign can_fetch = slot_ok && !cmd_load && !rd8_req && !code[0]
                       && !flags.fetched && !flags.cmd_pend;
    assign src       = can_fetch ? pick_src(code, flags.rd_pend) : SRC_NONE;
    assign completes = (src == SRC_VRAM_LO) || (src == SRC_VRAM8)
                       || (src == SRC_CRAM) || (src == SRC_VSRAM);
    assign rd16_ack  = rd16_req && flags.fetched && !cmd_load && !rd8_req;

    always_ff @(posedge clk) begin
        if (rst) begin
            code     <= CODE_IDLE;
            addr     <= '0;
            flags    <= '0;
            prefetch <= '0;
        end else if (cmd_load) begin
            code  <= cmd_code;
            addr  <= cmd_addr;
            flags <= '0;
        end else begin
            if (cmd_hi) flags.cmd_pend <= 1'b1;
            if (rd8_req) begin
                flags.cmd_pend <= 1'b0;
                flags.fetched  <= 1'b0;
                code           <= CODE_VRAM8;
            end else begin
                if (rd16_ack) flags.fetched <= 1'b0;
                if (src != SRC_NONE) prefetch <= pf_next;
                if (src == SRC_VRAM_HI) flags.rd_pend <= 1'b1;
                if (completes) begin
                    flags.rd_pend <= 1'b0;
                    flags.fetched <= 1'b1;
                    addr          <= addr + incr_ext;
                end
            end
        end
    end

    // R2
    vram_phase_chk: assert property (@(posedge clk) disable iff (rst)
        (src == SRC_VRAM_HI) |=> (flags.rd_pend && !flags.fetched));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        completes |=> (addr == $past(addr) + $past(incr_ext)));

    // R7
    ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
        rd16_ack |=> !flags.fetched);

    // R8
    byte_read_chk: assert property (@(posedge clk) disable iff (rst)
        (rd8_req && !cmd_load) |=> (code == CODE_VRAM8 && !flags.fetched
                                    && !flags.cmd_pend && $stable(addr)));

endmodule

// File: rtl/vram_prefetch_top.sv
module vram_prefetch_top
    import vram_prefetch_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int INCR_W     = 8,
    parameter int CRAM_DEPTH = 64,
    parameter int CRAM_W     = 9,
    parameter int VS_DEPTH   = 40,
    parameter int VS_W       = 11,
    parameter int VS_SPAN    = 64,
    localparam int CRAM_AW   = $clog2(CRAM_DEPTH),
    localparam int VS_AW     = $clog2(VS_SPAN)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               cmd_hi,
    input  logic               cmd_load,
    input  logic [3:0]         cmd_code,
    input  logic [ADDR_W-1:0]  cmd_addr,
    input  logic [INCR_W-1:0]  incr,
    input  logic               slot_ok,
    output logic [ADDR_W-1:0]  vram_addr,
    output logic               vram_re,
    input  logic [7:0]         vram_rdata,
    output logic [CRAM_AW-1:0] cram_idx,
    output logic               cram_re,
    input  logic [CRAM_W-1:0]  cram_rdata,
    output logic [VS_AW-1:0]   vsram_idx,
    output logic               vsram_re,
    input  logic [VS_W-1:0]    vsram_rdata,
    input  logic [15:0]        fifo_val,
    input  logic               rd16_req,
    output logic               rd16_ack,
    input  logic               rd8_req,
    output logic [15:0]        rd_data,
    output logic               pf_ready
);
    fetch_src_e        src;
    logic [3:0]        code;
    logic [ADDR_W-1:0] addr;
    pf_flags_t         flags;
    logic [WORD_W-1:0] prefetch;
    logic [WORD_W-1:0] pf_next;

    vram_prefetch_ctrl #(.ADDR_W(ADDR_W), .INCR_W(INCR_W)) u_ctrl (
        .clk(clk), .rst(rst), .cmd_hi(cmd_hi), .cmd_load(cmd_load),
        .cmd_code(cmd_code), .cmd_addr(cmd_addr), .incr(incr),
        .slot_ok(slot_ok), .rd16_req(rd16_req), .rd8_req(rd8_req),
        .pf_next(pf_next), .src(src), .code(code), .addr(addr),
        .flags(flags), .prefetch(prefetch), .rd16_ack(rd16_ack)
    );

    vram_prefetch_addr #(.ADDR_W(ADDR_W), .CRAM_AW(CRAM_AW), .VS_AW(VS_AW),
                         .VS_DEPTH(VS_DEPTH)) u_addr (
        .addr(addr), .src(src), .vram_addr(vram_addr), .vram_re(vram_re),
        .cram_idx(cram_idx), .cram_re(cram_re),
        .vsram_idx(vsram_idx), .vsram_re(vsram_re)
    );

    vram_prefetch_merge #(.CRAM_W(CRAM_W), .VS_W(VS_W)) u_merge (
        .src(src), .prefetch(prefetch), .vram_rdata(vram_rdata),
        .cram_rdata(cram_rdata), .vsram_rdata(vsram_rdata),
        .fifo_val(fifo_val), .pf_next(pf_next)
    );

    assign rd_data  = prefetch;
    assign pf_ready = flags.fetched;

    // R1
    fetch_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (vram_re || cram_re || vsram_re) |-> (slot_ok && !pf_ready && !code[0]
                                              && !flags.cmd_pend));

    // R1
    one_mem_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0({vram_re, cram_re, vsram_re}));

    // R6
    vs_range_chk: assert property (@(posedge clk) disable iff (rst)
        vsram_re |-> (int'(vsram_idx) < VS_DEPTH));

    // R1
    hold_word_chk: assert property (@(posedge clk) disable iff (rst)
        (pf_ready && !cmd_load && !rd8_req) |=> $stable(prefetch));

endmodule

// File: tb/vram_prefetch_top_test.sv
module vram_prefetch_top_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_hi = 1'b0, cmd_load = 1'b0;
    logic [3:0]  cmd_code = 4'h1;
    logic [15:0] cmd_addr = '0;
    logic [7:0]  incr = 8'd2;
    logic        slot_ok = 1'b0;
    logic [15:0] vram_addr;
    logic        vram_re, cram_re, vsram_re;
    logic [7:0]  vram_rdata;
    logic [5:0]  cram_idx, vsram_idx;
    logic [8:0]  cram_rdata;
    logic [10:0] vsram_rdata;
    logic [15:0] fifo_val = 16'h0000;
    logic        rd16_req = 1'b0, rd16_ack, rd8_req = 1'b0;
    logic [15:0] rd_data;
    logic        pf_ready;

    int n_cmp = 0;
    int n_bad = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    logic [15:0] last_word = 16'h0000;

    always #5 clk = ~clk;

    vram_prefetch_top uut (
        .clk(clk), .rst(rst), .cmd_hi(cmd_hi), .cmd_load(cmd_load),
        .cmd_code(cmd_code), .cmd_addr(cmd_addr), .incr(incr), .slot_ok(slot_ok),
        .vram_addr(vram_addr), .vram_re(vram_re), .vram_rdata(vram_rdata),
        .cram_idx(cram_idx), .cram_re(cram_re), .cram_rdata(cram_rdata),
        .vsram_idx(vsram_idx), .vsram_re(vsram_re), .vsram_rdata(vsram_rdata),
        .fifo_val(fifo_val), .rd16_req(rd16_req), .rd16_ack(rd16_ack),
        .rd8_req(rd8_req), .rd_data(rd_data), .pf_ready(pf_ready)
    );

    function automatic logic [7:0] vb(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
    endfunction
    function automatic logic [8:0] cf(input int i);
        return 9'((i * 37 + 5) & 32'h1FF);
    endfunction
    function automatic logic [10:0] vf(input int i);
        return 11'((i * 91 + 17) & 32'h7FF);
    endfunction
    function automatic logic [15:0] cexp(input int i);
        return ({7'h00, cf(i)} & 16'h01FF) | (fifo_val & ~16'h01FF);
    endfunction
    function automatic logic [15:0] vexp(input int i);
        return ({5'h00, vf(i)} & 16'h07FF) | (fifo_val & ~16'h07FF);
    endfunction

    // memory models answer in the same cycle
    assign vram_rdata  = vb(vram_addr);
    assign cram_rdata  = cf(int'(cram_idx));
    assign vsram_rdata = vf(int'(vsram_idx));

    task automatic check(input bit ok, input string req, input logic [15:0] act,
                         input logic [15:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        #3;
        if (rd16_ack) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R7 unexpected ack", rd_data, 16'h0000);
            end else begin
                logic [15:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rd_data == e, t, rd_data, e);
            end
        end
    end

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask
    task automatic load(input logic [3:0] c, input logic [15:0] a);
        cmd_code = c; cmd_addr = a; cmd_load = 1'b1;
        @(negedge clk);
        cmd_load = 1'b0;
    endtask
    task automatic slot();
        slot_ok = 1'b1;
        @(negedge clk);
        slot_ok = 1'b0;
    endtask
    task automatic rd16(input logic [15:0] e, input string t);
        exp_q.push_back(e);
        tag_q.push_back(t);
        last_word = e;
        rd16_req = 1'b1;
        forever begin
            #3;
            if (rd16_ack) break;
            @(negedge clk);
        end
        @(negedge clk);
        rd16_req = 1'b0;
    endtask
    task automatic rd8(input logic [15:0] e, input string t);
        rd8_req = 1'b1;
        #3;
        check(rd_data == e, t, rd_data, e);
        @(negedge clk);
        rd8_req = 1'b0;
    endtask
    task automatic ready_is(input bit v, input string t);
        #1;
        check(pf_ready == v, t, {15'h0, pf_ready}, {15'h0, v});
    endtask

    initial begin
        #(100000 * 10);
        check(1'b0, "watchdog expired", 16'h0, 16'h0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        idle(3);
        rst = 1'b0;
        idle(1);
        ready_is(0, "R9 reset ready low");
        slot(); slot();
        ready_is(0, "R9 idle code does not fetch");

        // R2 two-phase word, R1 hold while ready
        incr = 8'd2;
        load(4'h0, 16'h0100);
        slot();
        ready_is(0, "R2 one slot not enough");
        slot();
        ready_is(1, "R2 ready after two slots");
        slot(); slot();
        rd16({vb(16'h0100), vb(16'h0101)}, "R2 word at 0x0100 (R1 held)");
        ready_is(0, "R7 ready cleared by read");

        // R3 next word follows by increment
        slot(); slot();
        rd16({vb(16'h0102), vb(16'h0103)}, "R3 word at 0x0102");

        // R7 stall until fetched
        fork
            rd16({vb(16'h0104), vb(16'h0105)}, "R7 stalled read");
            begin
                #3;
                check(!rd16_ack, "R7 no ack before fetch", {15'h0, rd16_ack}, 16'h0);
                @(negedge clk);
                idle(2);
                #3;
                check(!rd16_ack, "R7 still stalled", {15'h0, rd16_ack}, 16'h0);
                @(negedge clk);
                slot(); slot();
            end
        join

        // R3 odd increment, odd start
        incr = 8'd3;
        load(4'h0, 16'h0203);
        slot(); slot();
        rd16({vb(16'h0202), vb(16'h0203)}, "R2 odd start address");
        slot(); slot();
        rd16({vb(16'h0206), vb(16'h0207)}, "R3 step of 3");

        // R4 byte read
        fifo_val = 16'hBEEF;
        incr = 8'd1;
        load(4'hC, 16'h0040);
        slot();
        ready_is(1, "R4 one slot suffices");
        rd16({8'hBE, vb(16'h0040)}, "R4 byte at 0x0040");
        slot();
        rd16({8'hBE, vb(16'h0041)}, "R4 byte at 0x0041");

        // R5 colour RAM
        fifo_val = 16'hF00F;
        incr = 8'd2;
        load(4'h8, 16'h0086);
        slot();
        rd16(cexp(3), "R5 index 3");
        slot();
        rd16(cexp(4), "R5 index 4");
        load(4'h8, 16'h00FE);
        slot();
        rd16(cexp(63), "R5 index 63");
        slot();
        rd16(cexp(0), "R5 index wraps to 0");

        // R6 scroll RAM
        fifo_val = 16'h5A5A;
        load(4'h4, 16'h004E);
        slot();
        rd16(vexp(39), "R6 last valid index");
        slot();
        rd16(vexp(0), "R6 index 40 forced to 0");
        load(4'h4, 16'h0090);
        slot();
        rd16(vexp(8), "R6 index masked to 8");

        // R10 non-fetching codes
        load(4'h1, 16'h0000);
        slot(); slot();
        ready_is(0, "R10 write code never fetches");
        load(4'h2, 16'h0000);
        slot(); slot();
        ready_is(0, "R10 unknown even code never fetches");

        // R9 load clears read-pending
        load(4'h0, 16'h0400);
        slot();
        load(4'h0, 16'h0500);
        slot();
        ready_is(0, "R9 load restarts word");
        slot();
        rd16({vb(16'h0500), vb(16'h0501)}, "R9 word at 0x0500");

        // R1 pending command blocks, R8 byte read clears it
        fifo_val = 16'h7700;
        incr = 8'd1;
        load(4'h0, 16'h0300);
        cmd_hi = 1'b1;
        @(negedge clk);
        cmd_hi = 1'b0;
        slot(); slot();
        ready_is(0, "R1 pending command blocks fetch");
        rd8(last_word, "R8 returns held word");
        slot();
        ready_is(1, "R8 pending cleared and byte mode");
        rd16({8'h77, vb(16'h0300)}, "R8 byte mode at 0x0300");
        slot();
        rd8({8'h77, vb(16'h0301)}, "R8 returns fetched byte word");
        ready_is(0, "R8 ready cleared");
        slot();
        rd16({8'h77, vb(16'h0302)}, "R3 address unchanged by byte read");

        idle(2);
        check(exp_q.size() == 0, "R7 scoreboard drained", 16'(exp_q.size()), 16'h0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule